// File: doc/BRIEF.md
# Framed Byte-Stream Receiver with CRC-8 Check

This block sits behind a serial byte receiver and watches the incoming byte stream, one byte per `rx_valid` strobe, for framed messages. A frame opens with a start marker and then carries a type byte, a three-byte destination address, a two-byte payload length, the payload itself (1 to 1024 bytes), a check byte and a closing marker. The header fields are captured into output registers, where downstream logic can read them. Each payload byte is forwarded to a buffer RAM as one write pulse with its own address.

While the frame streams in, the block folds every covered byte into a running CRC-8. When the closing slot arrives, it issues exactly one one-cycle outcome pulse: message accepted, check mismatch, missing end marker, or (earlier, right after the length field) bad length. It then goes back to hunting for the next start marker.

Top module: `frame_rx`

## Requirements
- R1: While hunting for a frame, any valid byte other than the start marker 0x7E is discarded: no write pulse, no outcome pulse, and the header registers keep their values.
- R2: After the start marker, the next byte is latched into `hdr_type`. The following three bytes form `hdr_addr` with the most significant byte first. The following two bytes form `hdr_len` with the most significant byte first. All of these hold until a later frame overwrites them.
- R3: Each payload byte produces exactly one cycle of `wr_en`, one cycle after it is accepted. `wr_data` carries the byte and `wr_addr` counts 0, 1, 2, … within the frame.
- R4: The received check byte, the one after the last payload byte, is latched into `hdr_crc`. The expected value is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, no reflection and no final XOR. It is computed MSB-first over the type, address, length and payload bytes, in arrival order. The start, check and end bytes are not included.
- R5: If the byte after the check byte is 0x7F and the check matches, `msg_ok` is high for exactly one cycle, in the cycle after that byte is accepted.
- R6: If the end marker is present but the computed CRC differs from the received one, `crc_err` is high for one cycle in place of `msg_ok`.
- R7: If the byte in the end slot is not 0x7F, `eof_err` is high for one cycle. This takes precedence over a CRC mismatch.
- R8: If the assembled length is 0 or greater than 1024, `len_err` is high for one cycle, in the cycle after the second length byte. No payload is written, and the block returns to hunting.
- R9: Bytes presented with `rx_valid` low have no effect, so idle gaps between the bytes of a frame are tolerated.
- R10: After reset, all outputs are zero.
- R11: At most one outcome pulse is high in any cycle, and after any outcome the block accepts a new frame starting with the very next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a new byte this cycle |
| wr_en | output | 1 | Payload write strobe to the buffer RAM |
| wr_addr | output | 10 | Payload byte index within the frame |
| wr_data | output | 8 | Payload byte |
| hdr_type | output | 8 | Latched type field |
| hdr_addr | output | 24 | Latched address field |
| hdr_len | output | 16 | Latched payload length |
| hdr_crc | output | 8 | Latched received check byte |
| msg_ok | output | 1 | One-cycle pulse: frame accepted |
| crc_err | output | 1 | One-cycle pulse: check mismatch |
| eof_err | output | 1 | One-cycle pulse: end marker missing |
| len_err | output | 1 | One-cycle pulse: length out of range |

## Verification
Every result is registered once, so it appears exactly one clock after the byte that causes it. A header register changes one clock after its byte. A write strobe follows one clock after its payload byte. An outcome pulse follows one clock after the end-slot byte, or after the second length byte for a bad length. The bench drives each byte on a falling edge and samples on the next falling edge, so the result of the byte just driven is read half a cycle after the edge that registered it. One further falling edge later, the bench confirms that the pulse has dropped again. Writes are gathered by a falling-edge monitor and compared only once the frame's outcome is known, which is at least two bytes after the last write.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int          MAX_LEN    = 1024,
  parameter int          ADDR_BYTES = 3,
  parameter int          LEN_BYTES  = 2,
  parameter logic [7:0]  SOF_BYTE   = 8'h7E,
  parameter logic [7:0]  EOF_BYTE   = 8'h7F,
  parameter logic [7:0]  CRC_POLY   = 8'h07,
  parameter logic [7:0]  CRC_INIT   = 8'h00,
  localparam int         AW = ADDR_BYTES * 8,
  localparam int         LW = LEN_BYTES * 8,
  localparam int         BW = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          wr_en,
  output logic [BW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [7:0]    hdr_type,
  output logic [AW-1:0] hdr_addr,
  output logic [LW-1:0] hdr_len,
  output logic [7:0]    hdr_crc,
  output logic          msg_ok,
  output logic          crc_err,
  output logic          eof_err,
  output logic          len_err
);

  typedef enum logic [2:0] {S_HUNT, S_TYPE, S_ADDR, S_LEN, S_DATA, S_CHK, S_END} state_t;

  state_t        st;
  logic [LW-1:0] cnt;
  logic [7:0]    crc;
  logic [7:0]    crc_nx;
  logic [LW-1:0] len_nx;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? {r[6:0], 1'b0} ^ CRC_POLY : {r[6:0], 1'b0};
    return r;
  endfunction

  assign crc_nx = crc_step(crc, rx_data);
  assign len_nx = LW'({hdr_len, rx_data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      cnt      <= '0;
      crc      <= CRC_INIT;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      hdr_type <= '0;
      hdr_addr <= '0;
      hdr_len  <= '0;
      hdr_crc  <= '0;
      msg_ok   <= 1'b0;
      crc_err  <= 1'b0;
      eof_err  <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      msg_ok  <= 1'b0;
      crc_err <= 1'b0;
      eof_err <= 1'b0;
      len_err <= 1'b0;
      if (rx_valid) begin
        case (st)
          S_HUNT: begin
            if (rx_data == SOF_BYTE) begin
              st  <= S_TYPE;
              crc <= CRC_INIT;
            end
          end
          S_TYPE: begin
            hdr_type <= rx_data;
            crc      <= crc_nx;
            cnt      <= '0;
            st       <= S_ADDR;
          end
          S_ADDR: begin
            hdr_addr <= AW'({hdr_addr, rx_data});
            crc      <= crc_nx;
            if (cnt == LW'(ADDR_BYTES - 1)) begin
              cnt <= '0;
              st  <= S_LEN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_LEN: begin
            hdr_len <= len_nx;
            crc     <= crc_nx;
            if (cnt == LW'(LEN_BYTES - 1)) begin
              cnt <= '0;
              if (len_nx == '0 || len_nx > LW'(MAX_LEN)) begin
                len_err <= 1'b1;
                st      <= S_HUNT;
              end else begin
                st <= S_DATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= cnt[BW-1:0];
            wr_data <= rx_data;
            crc     <= crc_nx;
            if (cnt == hdr_len - 1'b1) st <= S_CHK;
            else                       cnt <= cnt + 1'b1;
          end
          S_CHK: begin
            hdr_crc <= rx_data;
            st      <= S_END;
          end
          S_END: begin
            st <= S_HUNT;
            if (rx_data != EOF_BYTE) eof_err <= 1'b1;
            else if (crc != hdr_crc) crc_err <= 1'b1;
            else                     msg_ok  <= 1'b1;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_ok, crc_err, eof_err, len_err}));

  a_r5_ok_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ok |-> ($past(rx_valid) && $past(rx_data) == EOF_BYTE));

  a_r7_end_missing: assert property (@(posedge clk) disable iff (!rst_n)
    eof_err |-> ($past(rx_valid) && $past(rx_data) != EOF_BYTE));

  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (hdr_len == '0 || hdr_len > LW'(MAX_LEN)));

  a_r3_write_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rx_valid) && wr_data == $past(rx_data)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == BW'($past(wr_addr) + 1'b1)));

  a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> !(wr_en || msg_ok || crc_err || eof_err || len_err));

endmodule

// File: tb/frame_rx_bench.sv
module frame_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  hdr_type;
  logic [23:0] hdr_addr;
  logic [15:0] hdr_len;
  logic [7:0]  hdr_crc;
  logic        msg_ok, crc_err, eof_err, len_err;

  always #10 clk = ~clk;

  frame_rx u_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hdr_type(hdr_type), .hdr_addr(hdr_addr), .hdr_len(hdr_len), .hdr_crc(hdr_crc),
    .msg_ok(msg_ok), .crc_err(crc_err), .eof_err(eof_err), .len_err(len_err)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] cap [1024];
  int wcount = 0;
  int addr_bad = 0;

  always @(negedge clk) begin
    if (wr_en) begin
      if (wcount < 1024) cap[wcount] = wr_data;
      if (int'(wr_addr) != wcount) addr_bad++;
      wcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c;
    for (int j = 7; j >= 0; j--) begin
      logic fb = x[7] ^ d[j];
      x = {x[6:0], 1'b0};
      if (fb) x = x ^ 8'h07;
    end
    return x;
  endfunction

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37) ^ 8'(i >> 3);
  endfunction

  task automatic put(input logic [7:0] b, input bit gap);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h7E;
    if (gap) repeat (2) @(negedge clk);
  endtask

  task automatic outcome(input int exp, input string req);
    chk(msg_ok  == (exp == 0), req, "msg_ok",  msg_ok,  exp == 0);
    chk(crc_err == (exp == 1), req, "crc_err", crc_err, exp == 1);
    chk(eof_err == (exp == 2), req, "eof_err", eof_err, exp == 2);
    chk(len_err == (exp == 3), req, "len_err", len_err, exp == 3);
  endtask

  task automatic run_frame(input logic [7:0] typ, input logic [23:0] adr, input logic [15:0] len,
                           input logic [7:0] seed, input logic [1:0] mode, input bit gap,
                           input int exp);
    logic [7:0] c = 8'h00;
    logic [7:0] hb [6];
    logic [7:0] ck;
    int n;
    int mism = 0;
    hb = '{typ, adr[23:16], adr[15:8], adr[7:0], len[15:8], len[7:0]};
    wcount   = 0;
    addr_bad = 0;
    put(8'h7E, gap);
    for (int k = 0; k < 6; k++) begin
      c = crc_add(c, hb[k]);
      put(hb[k], gap && k != 5);
    end
    if (exp == 3) begin
      outcome(3, "R8");
    end else begin
      if (gap) repeat (2) @(negedge clk);
      for (int i = 0; i < int'(len); i++) begin
        c = crc_add(c, pay(seed, i));
        put(pay(seed, i), gap);
      end
      ck = mode[0] ? c ^ 8'h01 : c;
      put(ck, gap);
      put(mode[1] ? 8'h00 : 8'h7F, 1'b0);
      outcome(exp, exp == 0 ? "R5" : exp == 1 ? "R6" : "R7");
      chk(hdr_crc == ck, "R4", "hdr_crc", hdr_crc, ck);
    end
    chk(hdr_type == typ, "R2", "hdr_type", hdr_type, typ);
    chk(hdr_addr == adr, "R2", "hdr_addr", hdr_addr, adr);
    chk(hdr_len == len, "R2", "hdr_len", hdr_len, len);
    n = (exp == 3) ? 0 : int'(len);
    chk(wcount == n, "R3", "write count", wcount, n);
    chk(addr_bad == 0, "R3", "write address order", addr_bad, 0);
    for (int i = 0; i < n && i < 1024; i++) if (cap[i] != pay(seed, i)) mism++;
    chk(mism == 0, "R3", "payload mismatches", mism, 0);
    @(negedge clk);
    chk({msg_ok, crc_err, eof_err, len_err} == 4'b0, "R11", "pulse cleared",
        {msg_ok, crc_err, eof_err, len_err}, 0);
  endtask

  // {type, addr, len, seed, mode(bit0 bad check, bit1 bad end), gap, expected(0 ok,1 crc,2 end,3 len)}
  localparam int NV = 9;
  localparam logic [60:0] VEC [NV] = '{
    {8'h01, 24'h123456, 16'd1,    8'h00, 2'd0, 1'b0, 2'd0},
    {8'hA5, 24'h000010, 16'd5,    8'h3C, 2'd0, 1'b1, 2'd0},
    {8'h33, 24'hFFFFFF, 16'd16,   8'h11, 2'd1, 1'b0, 2'd1},
    {8'h40, 24'h00AB00, 16'd3,    8'h77, 2'd2, 1'b0, 2'd2},
    {8'h02, 24'h010203, 16'd0,    8'h00, 2'd0, 1'b0, 2'd3},
    {8'h03, 24'h000000, 16'd1025, 8'h00, 2'd0, 1'b1, 2'd3},
    {8'h7E, 24'h7E7F7E, 16'd4,    8'h7E, 2'd0, 1'b1, 2'd0},
    {8'h44, 24'h0F0F0F, 16'd2,    8'h21, 2'd3, 1'b0, 2'd2},
    {8'h09, 24'h00000A, 16'd1024, 8'h5A, 2'd0, 1'b0, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({wr_en, msg_ok, crc_err, eof_err, len_err} == 5'b0, "R10", "pulses in reset",
        {wr_en, msg_ok, crc_err, eof_err, len_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hdr_type, hdr_addr, hdr_len, hdr_crc, wr_addr, wr_data} == '0, "R10", "registers after reset",
        {hdr_type, hdr_addr, hdr_len, hdr_crc}, 0);

    foreach (VEC[v])
      run_frame(VEC[v][60:53], VEC[v][52:29], VEC[v][28:13], VEC[v][12:5],
                VEC[v][4:3], VEC[v][2], int'(VEC[v][1:0]));

    // R1: stray bytes while hunting
    wcount = 0;
    put(8'h00, 1'b0);
    put(8'h7F, 1'b0);
    put(8'h55, 1'b0);
    chk({msg_ok, crc_err, eof_err, len_err} == 4'b0, "R1", "pulse on stray byte",
        {msg_ok, crc_err, eof_err, len_err}, 0);
    chk(wcount == 0, "R1", "write on stray byte", wcount, 0);
    chk(hdr_type == 8'h09 && hdr_len == 16'd1024, "R1", "header disturbed",
        {hdr_type, hdr_len}, {8'h09, 16'd1024});

    // R9: start marker with valid low, then header bytes with valid low
    rx_data = 8'h7E;
    repeat (3) @(negedge clk);
    rx_data = 8'h00;
    repeat (3) @(negedge clk);
    put(8'h66, 1'b0);
    chk(hdr_type == 8'h09, "R9", "unqualified start accepted", hdr_type, 8'h09);

    run_frame(8'hC3, 24'hABCDEF, 16'd7, 8'h90, 2'd0, 1'b0, 0);

    // R11: reset mid-frame then a clean frame
    put(8'h7E, 1'b0);
    put(8'h12, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hdr_type == 8'h00, "R10", "type cleared by reset", hdr_type, 0);
    run_frame(8'h5D, 24'h000001, 16'd2, 8'hE1, 2'd0, 1'b1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule